// File: doc/BRIEF.md
# Microprogram Sequencer with Address Boosting

This block steps through a 64-word, 36-bit read-only microprogram and hands the current microword to a processor datapath as a vector of control bits. Each microword names its successor in a 6-bit next-address field. Before that value is used, the sequencer alters it in four ways. Console switch codes are ORed in. The indirect-addressing test and the opcode class steer the operand path. A data-channel request diverts control at an instruction boundary. In the top quarter of the store the opcode is substituted into the low four address bits, so each instruction is dispatched through a single word.

The datapath supplies three inputs: the instruction word fields (a 4-bit opcode and an indirect flag), a memory-cycle-done handshake and a data-channel request. A microword that starts a memory cycle and does not ask to continue is held until the handshake arrives. Every other word advances on the next clock. The microword output and the address output are both registered, so the control bits stay stable for a whole microstep. All addresses below are in octal.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high reset sets the address to 00, makes the control output all zeros and clears the instruction register.
- R2: The control output is the stored word at the current address. Word position p (position 0 is the most significant) appears on ctrl[35-p]. The bench relies on these positions: start-memory 32, continue 30, done 21, indirect-test 20, load-instruction 8, defer 17.
- R3: A word with start-memory set and continue clear keeps the same address and control output until mem_done is sampled high. It then advances.
- R4: Every other word advances on each clock to its modified next address. The raw next address sits in word positions 23 to 28, with position 28 as its most significant bit.
- R5: When the raw next address lies in 00 to 07, it is ORed with panel_code, and also with 6 while start_sw is high. Outside that range both inputs have no effect.
- R6: A word with indirect-test set that targets 30 goes to 31 when the instruction register's indirect bit is set.
- R7: Without indirection, that same target becomes 32 for opcodes 0 to 3.
- R8: Without indirection, opcodes 10 and 14 to 17 skip 30 and go straight to 60 ORed with the opcode. All other opcodes go to 30.
- R9: Any modified next address in 60 to 77 has its low four bits replaced by the opcode (instruction register bits 4:1).
- R10: The instruction register loads ir_in (opcode in bits 4:1, indirect flag in bit 0) when a load-instruction word advances. A defer word clears the indirect flag, so the indirect pass through 31 happens at most once per instruction.
- R11: dch_req ORs 20 into the next address only when the current word has done set and targets 10. Everywhere else it has no effect.
- R12: With no switch input, the sequencer idles at address 00.
- R13: The store holds these words (address: bits, target): 06 start-memory, 21; 10 start-memory, 21; 21 continue, 12; 12 load-instruction, 24; 24 indirect-test and start-memory, 30; 30 defer, 60; 31 defer, 24; 32 continue, 23; 23 continue, 60; 70 indirect-test and start-memory, 33; 33 load-instruction, 24; 76 no bits, 20; 20 done and continue, 10. Every other word in 60 to 77 is done and continue, target 10. Every remaining word is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_sw | input | 1 | Start switch; ORs 6 into a low-range target |
| panel_code | input | 3 | Console code ORed into a low-range target |
| mem_done | input | 1 | Memory cycle finished; releases a held word |
| dch_req | input | 1 | Data-channel request, sampled at the instruction boundary |
| ir_in | input | 5 | Opcode in bits 4:1, indirect flag in bit 0 |
| ctrl | output | 36 | Registered control bits of the current microword |
| uaddr | output | 6 | Current control-store address |

## Verification
On every cycle, the assertions check the following: a held memory word keeps its address and output; start_sw forces the low address bits to 6 or 7; entry into the dispatch region carries the opcode; the defer word leaves the indirect flag clear; and an accepted data-channel request lands on 30. Only the bench's scenarios can show complete instruction paths. These include the fetch sequence, the single pass through the defer word, the re-fetch from 70 and 33, and the detour through 76 and 20. They also include each console code, the reset state, and the fact that console codes and data-channel requests have no effect away from their windows.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int AW = 6;
  localparam int WW = 36;
  localparam int IRW = 5;
  localparam int CW = 3;

  // word positions, position 0 = most significant
  localparam int P_MB_OUT = 3;
  localparam int P_MB_IN  = 4;
  localparam int P_AC_OUT = 6;
  localparam int P_IR_LD  = 8;
  localparam int P_AR_IN  = 10;
  localparam int P_XFER   = 11;
  localparam int P_PC_OUT = 12;
  localparam int P_PC_IN  = 13;
  localparam int P_DEFER  = 17;
  localparam int P_ITEST  = 20;
  localparam int P_DONE   = 21;
  localparam int P_NXT_LO = 23;
  localparam int P_CONT   = 30;
  localparam int P_INC    = 31;
  localparam int P_SM     = 32;
  localparam int P_SW_OUT = 33;

  function automatic int ix(input int p);
    return WW - 1 - p;
  endfunction

  function automatic logic [WW-1:0] fb(input int p);
    return {{(WW-1){1'b0}}, 1'b1} << ix(p);
  endfunction

  function automatic logic [AW-1:0] nxt_field(input logic [WW-1:0] w);
    logic [AW-1:0] n;
    for (int k = 0; k < AW; k++) n[k] = w[ix(P_NXT_LO + k)];
    return n;
  endfunction

  function automatic logic [WW-1:0] mk(input logic [WW-1:0] f, input logic [AW-1:0] n);
    logic [WW-1:0] w;
    w = f;
    for (int k = 0; k < AW; k++) w[ix(P_NXT_LO + k)] = n[k];
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AWID = AW,
  parameter int WWID = WW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [AWID-1:0] rd_addr,
  output logic [WWID-1:0] q
);
  function automatic logic [WW-1:0] word_at(input logic [AW-1:0] a);
    case (a)
      6'o06: return mk(fb(P_MB_IN) | fb(P_PC_IN) | fb(P_SW_OUT) | fb(P_SM), 6'o21);
      6'o10: return mk(fb(P_PC_OUT) | fb(P_SM), 6'o21);
      6'o12: return mk(fb(P_AC_OUT) | fb(P_IR_LD) | fb(P_AR_IN), 6'o24);
      6'o20: return mk(fb(P_DONE) | fb(P_CONT), 6'o10);
      6'o21: return mk(fb(P_MB_OUT) | fb(P_PC_IN) | fb(P_INC) | fb(P_CONT), 6'o12);
      6'o23: return mk(fb(P_MB_OUT) | fb(P_XFER) | fb(P_INC) | fb(P_CONT), 6'o60);
      6'o24: return mk(fb(P_ITEST) | fb(P_SM), 6'o30);
      6'o30: return mk(fb(P_XFER) | fb(P_DEFER), 6'o60);
      6'o31: return mk(fb(P_DEFER), 6'o24);
      6'o32: return mk(fb(P_AR_IN) | fb(P_PC_OUT) | fb(P_CONT), 6'o23);
      6'o33: return mk(fb(P_IR_LD), 6'o24);
      6'o70: return mk(fb(P_ITEST) | fb(P_SM), 6'o33);
      6'o76: return mk('0, 6'o20);
      default:
        if (a[AW-1:AW-2] == 2'b11)
          return mk(fb(P_MB_IN) | fb(P_DONE) | fb(P_CONT), 6'o10);
        else
          return '0;
    endcase
  endfunction

  // synchronous read of a constant store
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= word_at(AW'(rd_addr));
  end
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int AWID = AW,
  parameter int WWID = WW,
  parameter int IRWID = IRW,
  parameter int CWID = CW
) (
  input  logic [WWID-1:0]  word,
  input  logic [IRWID-1:0] ir,
  input  logic             start_sw,
  input  logic [CWID-1:0]  panel_code,
  input  logic             dch_req,
  output logic [AWID-1:0]  nxt
);
  localparam int OPW = IRWID - 1;

  logic [AWID-1:0] tgt;
  logic [OPW-1:0]  op;
  logic            ind;
  logic [CWID-1:0] sw;

  always_comb begin
    tgt = nxt_field(word);
    op  = ir[IRWID-1:1];
    ind = ir[0];
    sw  = panel_code | (start_sw ? CWID'(6) : '0);
    nxt = tgt;
    if (tgt[AWID-1:CWID] == '0)
      nxt = nxt | AWID'(sw);
    if (word[ix(P_ITEST)] && tgt == 6'o30) begin
      if (ind)                                nxt = nxt | 6'o01;
      else if (op < 4'o4)                     nxt = nxt | 6'o02;
      else if (op == 4'o10 || op >= 4'o14)    nxt = 6'o60;
    end
    if (word[ix(P_DONE)] && tgt == 6'o10 && dch_req)
      nxt = nxt | 6'o20;
    if (nxt[AWID-1:AWID-2] == 2'b11)
      nxt[OPW-1:0] = op;
  end
endmodule

// File: rtl/useq_ir.sv
module useq_ir
  import useq_pkg::*;
#(
  parameter int IRWID = IRW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clr_ind,
  input  logic [IRWID-1:0] din,
  output logic [IRWID-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load)    q <= din;
    else if (clr_ind) q[0] <= 1'b0;
  end

  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AWID = AW,
  parameter int WWID = WW,
  parameter int IRWID = IRW,
  parameter int CWID = CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_sw,
  input  logic [CWID-1:0]  panel_code,
  input  logic             mem_done,
  input  logic             dch_req,
  input  logic [IRWID-1:0] ir_in,
  output logic [WWID-1:0]  ctrl,
  output logic [AWID-1:0]  uaddr
);
  logic             adv;
  logic [AWID-1:0]  nxt;
  logic [IRWID-1:0] ir_q;

  assign adv = ctrl[ix(P_CONT)] | ~ctrl[ix(P_SM)] | mem_done;

  useq_nextaddr #(.AWID(AWID), .WWID(WWID), .IRWID(IRWID), .CWID(CWID)) u_nxt (
    .word(ctrl), .ir(ir_q), .start_sw(start_sw), .panel_code(panel_code),
    .dch_req(dch_req), .nxt(nxt)
  );

  useq_store #(.AWID(AWID), .WWID(WWID)) u_store (
    .clk(clk), .rst(rst), .en(adv), .rd_addr(nxt), .q(ctrl)
  );

  useq_ir #(.IRWID(IRWID)) u_ir (
    .clk(clk), .rst(rst),
    .load(adv & ctrl[ix(P_IR_LD)]),
    .clr_ind(adv & ctrl[ix(P_DEFER)]),
    .din(ir_in), .q(ir_q)
  );

  always_ff @(posedge clk) begin
    if (rst)      uaddr <= '0;
    else if (adv) uaddr <= nxt;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl[ix(P_SM)] && !ctrl[ix(P_CONT)] && !mem_done) |=> ($stable(uaddr) && $stable(ctrl)));

  p_console_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && start_sw && nxt_field(ctrl) < 6'o10) |=> (uaddr[2:1] == 2'b11));

  p_dispatch_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(uaddr[AWID-1:AWID-2] == 2'b11) |-> (uaddr[3:0] == ir_q[IRWID-1:1]));

  p_defer_once_r10: assert property (@(posedge clk) disable iff (rst)
    (uaddr == 6'o31) |=> !ir_q[0]);

  p_dch_r11: assert property (@(posedge clk) disable iff (rst)
    (adv && ctrl[ix(P_DONE)] && nxt_field(ctrl) == 6'o10 && dch_req) |=> (uaddr == 6'o30));
endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_sw = 1'b0;
  logic [2:0]  panel_code = '0;
  logic        mem_done = 1'b0;
  logic        dch_req = 1'b0;
  logic [4:0]  ir_in = '0;
  logic [35:0] ctrl;
  logic [5:0]  uaddr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  useq_top u0 (
    .clk(clk), .rst(rst), .start_sw(start_sw), .panel_code(panel_code),
    .mem_done(mem_done), .dch_req(dch_req), .ir_in(ir_in),
    .ctrl(ctrl), .uaddr(uaddr)
  );

  // control bit masks from R2: position p on ctrl[35-p]
  localparam logic [35:0] K_SM   = 36'd1 << (35 - 32);
  localparam logic [35:0] K_CONT = 36'd1 << (35 - 30);
  localparam logic [35:0] K_DONE = 36'd1 << (35 - 21);
  localparam logic [35:0] K_TI   = 36'd1 << (35 - 20);
  localparam logic [35:0] K_IRL  = 36'd1 << (35 - 8);
  localparam logic [35:0] K_DEF  = 36'd1 << (35 - 17);

  typedef struct {
    logic [5:0]  a;
    logic [35:0] m;
    logic [35:0] v;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic stepc(input logic [5:0] a, input logic [35:0] m,
                       input logic [35:0] v, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.a = a; e.m = m; e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input logic [5:0] a, input string tag);
    stepc(a, '0, '0, tag);
  endtask

  // monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (uaddr !== e.a) begin
        bad++;
        $display("FAIL %s addr actual=%o expected=%o", e.tag, uaddr, e.a);
      end
      if (e.m != '0) begin
        total++;
        if ((ctrl & e.m) !== e.v) begin
          bad++;
          $display("FAIL %s ctrl actual=%h expected=%h", e.tag, ctrl & e.m, e.v);
        end
      end
    end
  end

  // fetch from 10 through 24, leaving the sequencer at the test outcome
  task automatic fetch(input logic [3:0] op, input logic ind,
                       input logic [5:0] after24, input string tag);
    mem_done = 1'b1;
    step(6'o21, "R3");
    mem_done = 1'b0;
    step(6'o12, "R4");
    ir_in = {op, ind};
    stepc(6'o24, K_TI | K_SM, K_TI | K_SM, "R10");
    mem_done = 1'b1;
    step(after24, tag);
    mem_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    total++;
    if (uaddr !== 6'o00 || ctrl !== '0) begin
      bad++;
      $display("FAIL R1 reset actual=%o/%h expected=00/0", uaddr, ctrl);
    end
    step(6'o00, "R12");
    step(6'o00, "R12");

    // console codes
    panel_code = 3'd1; step(6'o01, "R5");
    panel_code = 3'd0; rst = 1'b1; stepc(6'o00, '1, '0, "R1");
    rst = 1'b0;
    panel_code = 3'd2; step(6'o02, "R5");
    panel_code = 3'd0; rst = 1'b1; step(6'o00, "R1");
    rst = 1'b0;
    panel_code = 3'd7; step(6'o07, "R5");
    panel_code = 3'd0; rst = 1'b1; step(6'o00, "R1");
    rst = 1'b0;

    // start and hold
    start_sw = 1'b1; stepc(6'o06, K_SM | K_CONT, K_SM, "R5");
    start_sw = 1'b0;
    step(6'o06, "R3");
    step(6'o06, "R3");
    mem_done = 1'b1; step(6'o21, "R3");
    mem_done = 1'b0;
    // console code and data channel ignored away from their windows
    panel_code = 3'd7; dch_req = 1'b1;
    step(6'o12, "R5 R11");
    panel_code = 3'd0; dch_req = 1'b0;
    ir_in = {4'o4, 1'b0};
    stepc(6'o24, K_TI, K_TI, "R10");
    step(6'o24, "R3");
    mem_done = 1'b1; step(6'o30, "R8");
    mem_done = 1'b0;
    stepc(6'o64, K_DONE | K_CONT, K_DONE | K_CONT, "R9");
    stepc(6'o10, K_SM | K_DONE, K_SM, "R4");

    // store-class opcode
    fetch(4'o2, 1'b0, 6'o32, "R7");
    step(6'o23, "R4");
    step(6'o62, "R9");
    step(6'o10, "R4");

    // indirect then direct dispatch
    fetch(4'o14, 1'b1, 6'o31, "R6");
    stepc(6'o24, K_DEF, '0, "R10");
    mem_done = 1'b1; step(6'o74, "R10 R8");
    mem_done = 1'b0;
    step(6'o10, "R4");

    // re-fetch path through 70 and 33
    fetch(4'o10, 1'b0, 6'o70, "R8");
    step(6'o70, "R3");
    mem_done = 1'b1; stepc(6'o33, K_IRL, K_IRL, "R2");
    mem_done = 1'b0;
    ir_in = {4'o7, 1'b0};
    step(6'o24, "R10");
    mem_done = 1'b1; step(6'o30, "R10 R8");
    mem_done = 1'b0;
    step(6'o67, "R9");
    step(6'o10, "R4");

    // detour through 76 and 20
    fetch(4'o16, 1'b0, 6'o76, "R8");
    step(6'o20, "R13");
    step(6'o10, "R13");

    // data channel at instruction boundary
    fetch(4'o5, 1'b0, 6'o30, "R8");
    step(6'o65, "R9");
    dch_req = 1'b1; step(6'o30, "R11");
    dch_req = 1'b0;
    step(6'o65, "R9");
    step(6'o10, "R4");

    // indirect store-class: defer once, then 32
    fetch(4'o3, 1'b1, 6'o31, "R6");
    step(6'o24, "R10");
    mem_done = 1'b1; step(6'o32, "R7");
    mem_done = 1'b0;
    step(6'o23, "R4");
    step(6'o63, "R9");
    step(6'o10, "R4");

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule